// File: doc/BRIEF.md
# Low-Order Interleaved Multi-Bank Word Memory

This block is a word-addressed memory made of several independent banks, each one word wide. The low address bits pick the bank and the remaining bits pick the row inside it, so consecutive words land in different banks. Each word operation passes through three phases. An address phase occupies the shared issue slot. A bank access keeps the chosen bank busy. A transfer phase brings read data back. Operations aimed at different banks overlap, one issue slot apart. An operation aimed at a bank that is still busy holds the request port until that bank recovers.

A host issues single-word reads and writes over a valid/ready port. It can also ask for a whole aligned block of words with one request. An internal sequencer expands that request into consecutive word reads in ascending order. Each word read is issued at the earliest slot the timing rules allow. Read results come back as single-cycle pulses tagged with the word address. Every read has the same fixed latency, so results arrive in issue order. Writes return nothing.

Top module: `ilv_mem`

## Requirements
- R1: The bank of a word is its address modulo NUM_BANKS (address bits [1:0] with the defaults). The row inside the bank is the address divided by NUM_BANKS. A read returns the last data written to that address.
- R2: After reset, rsp_valid is low and req_ready is high. A request is taken only on a clock edge where req_valid and req_ready are both high.
- R3: Two word operations start no closer than ADDR_CYC clock edges apart (default 4).
- R4: A bank stays busy for ADDR_CYC+ACCESS_CYC edges (default 28) after it takes an operation. A request to a busy bank waits until that bank is free. A request to another bank is taken at the earliest edge that R3 allows.
- R5: A read taken at edge e raises rsp_valid for exactly one cycle, starting at edge e+ADDR_CYC+ACCESS_CYC+XFER_CYC-1. rsp_addr carries the read's address and rsp_data carries its data, so results appear in issue order.
- R6: A write (req_write=1, req_fill=0) stores req_wdata and never produces a response. It keeps its bank busy exactly as long as a read does.
- R7: A request with req_fill=1 reads FILL_WORDS words (default 4). The block starts at the request address with its low log2(FILL_WORDS) bits cleared, and req_write is ignored. The words are issued in ascending address order, each at the earliest edge that R3 and R4 permit.
- R8: req_ready stays low while words of an accepted block fill remain to be issued.
- R9: With the default timing and an idle memory, the second word of a block fill returns 36 cycles after the fill's accepting cycle. The fourth word returns 44 cycles after it, with both counts including the accepting cycle.
- R10: At most one read result is presented per cycle. Results for words in different banks issued back to back are spaced ADDR_CYC cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write word, 0 = read word (ignored for a fill) |
| req_fill | input | 1 | 1 = read an aligned block of FILL_WORDS words |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read result present this cycle |
| rsp_addr | output | ADDR_W | Word address of the result |
| rsp_data | output | DATA_W | Read data |

## Verification
The bench uses four kinds of traffic. An ascending sweep over every address first writes and then reads the whole array. It checks that four banks overlap and that the fifth word stalls on the recycled bank. A stride of NUM_BANKS keeps hitting one bank, which separates the full-recovery wait from the slot spacing. A write followed by a read of the same word shows that writes occupy the bank and that data lands in the right row. Block fills start from every aligned base and from a deliberately misaligned address with the write flag set. These fills check the alignment, the ascending order, the hidden-latency totals of 36 and 44 cycles, and that req_ready stays low until the last word is issued.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} op_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int ROW_W    = 6,
  parameter int BUSY_CYC = 28,
  parameter int XFER_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  op_e               acc_op_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic              free_o,
  output logic              rsp_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam int XC_W  = $clog2(XFER_CYC + 1);
  localparam int DEPTH = 1 << ROW_W;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [XC_W-1:0]   xcnt_q, xcnt_d;
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] tag_q, tag_d;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              done, done_rd;

  assign done    = (cnt_q == CNT_W'(1));
  assign done_rd = done && (op_q == OP_RD);

  always_comb begin
    cnt_d  = cnt_q;
    op_d   = op_q;
    addr_d = addr_q;
    if (acc_i) begin
      cnt_d  = CNT_W'(BUSY_CYC);
      op_d   = acc_op_i;
      addr_d = acc_addr_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    xcnt_d = xcnt_q;
    tag_d  = tag_q;
    if (done_rd) begin
      xcnt_d = XC_W'(XFER_CYC);
      tag_d  = addr_q;
    end else if (xcnt_q != '0) begin
      xcnt_d = xcnt_q - XC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      xcnt_q <= '0;
      op_q   <= OP_RD;
      addr_q <= '0;
      tag_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      xcnt_q <= xcnt_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      tag_q  <= tag_d;
    end
  end

  // Storage array: write at acceptance, read at the end of the access.
  always_ff @(posedge clk) begin
    if (acc_i && (acc_op_i == OP_WR)) begin
      mem_q[acc_addr_i[ADDR_W-1 -: ROW_W]] <= acc_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (done_rd) begin
      data_q <= mem_q[addr_q[ADDR_W-1 -: ROW_W]];
    end
  end

  assign free_o     = (cnt_q <= CNT_W'(1));
  assign rsp_o      = (xcnt_q == XC_W'(1));
  assign rsp_addr_o = tag_q;
  assign rsp_data_o = data_q;

  // R4: the steering logic never hands work to a bank still in its access
  assert_bank_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |-> (cnt_q <= CNT_W'(1)));

  // R6: a finishing write never starts a transfer
  assert_write_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_WR) |=> (xcnt_q == '0));
endmodule

// File: rtl/ilv_fill_seq.sv
module ilv_fill_seq #(
  parameter int ADDR_W     = 8,
  parameter int FILL_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int LEFT_W    = $clog2(FILL_WORDS);
  localparam int FILL_BITS = $clog2(FILL_WORDS);

  logic [LEFT_W-1:0] left_q, left_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    left_d = left_q;
    addr_d = addr_q;
    if (start_i) begin
      left_d = LEFT_W'(FILL_WORDS - 1);
      addr_d = base_i + ADDR_W'(1);
    end else if (step_i) begin
      left_d = left_q - LEFT_W'(1);
      addr_d = addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      addr_q <= '0;
    end else begin
      left_q <= left_d;
      addr_q <= addr_d;
    end
  end

  assign pend_o = (left_q != '0);
  assign addr_o = addr_q;

  // R8: no new block fill is taken while words of the last one remain
  assert_no_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !pend_o);

  // R7: sequenced words are never the first word of their block
  assert_fill_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && pend_o) |-> (addr_o[FILL_BITS-1:0] != '0));
endmodule

// File: rtl/ilv_mem.sv
module ilv_mem
  import ilv_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int NUM_BANKS  = 4,
  parameter int ADDR_CYC   = 4,
  parameter int ACCESS_CYC = 24,
  parameter int XFER_CYC   = 4,
  parameter int FILL_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_fill,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int BANK_BITS = $clog2(NUM_BANKS);
  localparam int ROW_W     = ADDR_W - BANK_BITS;
  localparam int FILL_BITS = $clog2(FILL_WORDS);
  localparam int BUSY_CYC  = ADDR_CYC + ACCESS_CYC;
  localparam int SLOT_W    = $clog2(ADDR_CYC + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  logic [NUM_BANKS-1:0] bank_free, bank_rsp;
  logic [ADDR_W-1:0]    bank_tag [NUM_BANKS];
  logic [DATA_W-1:0]    bank_dat [NUM_BANKS];
  logic [SLOT_W-1:0]    slot_q, slot_d;
  logic                 seq_pend;
  logic [ADDR_W-1:0]    seq_addr, host_addr, iss_addr;
  logic [BANK_BITS-1:0] iss_bank;
  op_e                  iss_op;
  logic                 slot_free, can_iss, host_acc, issue, fill_start;

  always_comb begin
    host_addr  = req_fill ? {req_addr[ADDR_W-1:FILL_BITS], {FILL_BITS{1'b0}}} : req_addr;
    iss_addr   = seq_pend ? seq_addr : host_addr;
    iss_op     = (seq_pend || req_fill || !req_write) ? OP_RD : OP_WR;
    iss_bank   = iss_addr[BANK_BITS-1:0];
    slot_free  = (slot_q <= SLOT_W'(1));
    can_iss    = slot_free && bank_free[iss_bank];
    req_ready  = !seq_pend && can_iss;
    host_acc   = req_valid && req_ready;
    issue      = seq_pend ? can_iss : host_acc;
    fill_start = host_acc && req_fill;
    slot_d     = slot_q;
    if (issue) begin
      slot_d = SLOT_W'(ADDR_CYC);
    end else if (slot_q != '0) begin
      slot_d = slot_q - SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  ilv_fill_seq #(.ADDR_W(ADDR_W), .FILL_WORDS(FILL_WORDS)) u_fill (
    .clk(clk), .rst_n(rst_i), .start_i(fill_start), .base_i(host_addr),
    .step_i(seq_pend && can_iss), .pend_o(seq_pend), .addr_o(seq_addr)
  );

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    ilv_bank #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ROW_W(ROW_W),
      .BUSY_CYC(BUSY_CYC), .XFER_CYC(XFER_CYC)
    ) u_bank (
      .clk(clk), .rst_n(rst_i),
      .acc_i(issue && (iss_bank == BANK_BITS'(gi))),
      .acc_op_i(iss_op), .acc_addr_i(iss_addr), .acc_wdata_i(req_wdata),
      .free_o(bank_free[gi]), .rsp_o(bank_rsp[gi]),
      .rsp_addr_o(bank_tag[gi]), .rsp_data_o(bank_dat[gi])
    );
  end

  always_comb begin
    rsp_valid = 1'b0;
    rsp_addr  = '0;
    rsp_data  = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (bank_rsp[i]) begin
        rsp_valid = 1'b1;
        rsp_addr  = bank_tag[i];
        rsp_data  = bank_dat[i];
      end
    end
  end

  // Checker counter: edges since the last issue, saturating at ADDR_CYC
  logic [SLOT_W-1:0] since_q, since_d;
  always_comb begin
    since_d = since_q;
    if (issue)                          since_d = SLOT_W'(1);
    else if (since_q < SLOT_W'(ADDR_CYC)) since_d = since_q + SLOT_W'(1);
  end
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) since_q <= SLOT_W'(ADDR_CYC);
    else        since_q <= since_d;
  end

  // R3: issues keep at least one address phase apart
  assert_slot_spacing_R3: assert property (@(posedge clk) disable iff (!rst_i)
    issue |-> (since_q >= SLOT_W'(ADDR_CYC)));

  // R10: banks never present results in the same cycle
  assert_rsp_onehot_R10: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(bank_rsp));
endmodule

// File: tb/ilv_mem_tb.sv
`timescale 1ns/1ps
module ilv_mem_tb;
  localparam int AW = 8, DW = 32, NB = 4, AC = 4, XC = 24, TC = 4, FW = 4;
  localparam int BUSY = AC + XC;
  localparam int LAT  = AC + XC + TC;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, req_valid, req_ready, req_write, req_fill, rsp_valid;
  logic [AW-1:0] req_addr, rsp_addr;
  logic [DW-1:0] req_wdata, rsp_data;

  ilv_mem u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_fill(req_fill), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data)
  );

  typedef struct {int c; logic [AW-1:0] a; logic [DW-1:0] d;} exp_t;
  exp_t          expq[$];
  int            obs_c[$];
  logic [DW-1:0] mem [1 << AW];
  int            cyc = 0, checks = 0, fails = 0;
  int            slot_next = 0, host_min = 0;
  int            bank_next [NB];
  bit            mon_on = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return {8'(a), 8'(~a), 8'(a ^ 8'h5A ^ salt), 8'(a + 8'h33)};
  endfunction

  always @(negedge clk) begin
    exp_t e;
    if (mon_on) begin
      if (rsp_valid) begin
        obs_c.push_back(cyc);
        if (expq.size() == 0) begin
          chk(1'b0, "R6", "response with none pending", rsp_addr, 0);
        end else begin
          e = expq.pop_front();
          chk(cyc == e.c, "R5", "response cycle", cyc, e.c);
          chk(rsp_addr == e.a, "R5", "response address", rsp_addr, e.a);
          chk(rsp_data == e.d, "R1", "response data", rsp_data, e.d);
        end
      end else if (expq.size() != 0 && expq[0].c <= cyc) begin
        chk(1'b0, "R5", "missing response", cyc, expq[0].c);
        e = expq.pop_front();
      end
    end
  end

  // One host request; returns the accepting edge.
  task automatic send(input bit wr, input bit fl, input logic [AW-1:0] ad,
                      input logic [DW-1:0] wd, output int acc);
    logic [AW-1:0] ia;
    int            ex, e;
    ia = fl ? (ad & 8'hFC) : ad;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_fill = fl; req_addr = ad; req_wdata = wd;
    #1;
    ex = mx(mx(cyc + 1, host_min), mx(slot_next, bank_next[ia % NB]));
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    chk(acc == ex, fl ? "R7" : "R4", "accepting edge", acc, ex);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_fill = 1'b0;
    if (fl) begin
      e = acc;
      for (int k = 0; k < FW; k++) begin
        logic [AW-1:0] a;
        a = ia + AW'(k);
        if (k > 0) e = mx(slot_next, bank_next[a % NB]);
        slot_next = e + AC;
        bank_next[a % NB] = e + BUSY;
        expq.push_back('{c: e + LAT - 1, a: a, d: mem[a]});
      end
      host_min = e + 1;
      #1;
      chk(req_ready == 1'b0, "R8", "ready while fill words pending", req_ready, 0);
    end else begin
      slot_next = acc + AC;
      bank_next[ia % NB] = acc + BUSY;
      host_min = acc + 1;
      if (wr) mem[ia] = wd;
      else    expq.push_back('{c: acc + LAT - 1, a: ia, d: mem[ia]});
    end
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int a0, a1, n0;
    for (int b = 0; b < NB; b++) bank_next[b] = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_fill = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rsp_valid == 1'b0, "R2", "rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R2", "req_ready after reset", req_ready, 1);
    mon_on = 1;

    // R1/R4: ascending write sweep over every address
    for (int a = 0; a < (1 << AW); a++) send(1'b1, 1'b0, AW'(a), pat(a, 0), a0);

    // R3: ascending read sweep, words in distinct banks one slot apart
    for (int a = 0; a < (1 << AW); a += NB) begin
      send(1'b0, 1'b0, AW'(a), '0, a0);
      send(1'b0, 1'b0, AW'(a + 1), '0, a1);
      chk(a1 - a0 == AC, "R3", "slot spacing of neighbouring banks", a1 - a0, AC);
      send(1'b0, 1'b0, AW'(a + 2), '0, a0);
      send(1'b0, 1'b0, AW'(a + 3), '0, a0);
    end
    drain();

    // R4: stride of NB keeps hitting bank 1
    send(1'b0, 1'b0, 8'd1, '0, a0);
    for (int a = 1 + NB; a < 64; a += NB) begin
      send(1'b0, 1'b0, AW'(a), '0, a1);
      chk(a1 - a0 == BUSY, "R4", "same-bank recovery", a1 - a0, BUSY);
      a0 = a1;
    end
    drain();

    // R6: write then read of one word
    for (int a = 5; a < 200; a += 37) begin
      send(1'b1, 1'b0, AW'(a), pat(a, 8'hC3), a0);
      send(1'b0, 1'b0, AW'(a), '0, a1);
      chk(a1 - a0 == BUSY, "R6", "write occupies its bank", a1 - a0, BUSY);
    end
    drain();

    // R9/R10: misaligned fill with write flag set, from idle
    repeat (40) @(negedge clk);
    n0 = obs_c.size();
    send(1'b1, 1'b1, 8'h21, 32'hDEAD_BEEF, a0);
    drain();
    chk(obs_c[n0 + 1] - a0 + 1 == 36, "R9", "second fill word total", obs_c[n0 + 1] - a0 + 1, 36);
    chk(obs_c[n0 + 3] - a0 + 1 == 44, "R9", "fourth fill word total", obs_c[n0 + 3] - a0 + 1, 44);
    for (int k = 0; k < FW - 1; k++)
      chk(obs_c[n0 + k + 1] - obs_c[n0 + k] == AC, "R10", "result spacing",
          obs_c[n0 + k + 1] - obs_c[n0 + k], AC);

    // R7: fill from every aligned base, mixed with single reads
    for (int a = 0; a < (1 << AW); a += FW) begin
      send(1'b0, 1'b1, AW'(a + (a % 3)), '0, a0);
      send(1'b0, 1'b0, AW'(255 - a), '0, a1);
    end
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule